// File: doc/BRIEF.md
# PC Breakpoint Context Qualifier

This block watches the instruction stream of a processor core for up to four programmed program-counter values. Each comparator holds a target instruction address, an 8-bit address-space identifier and an enable bit. It also holds a small qualification code that decides whether a matching address alone is enough. The code can also demand that the current address-space identifier matches, that the core is in a particular privilege mode, or both. Whenever the core presents a valid instruction address, every enabled comparator evaluates its address and qualifiers in parallel. The per-comparator results, and their OR, appear on registered outputs one clock later.

Software or a debug agent programs the block through a single write port. A select code picks one of four kinds of target: a comparator address, a comparator identifier, the packed qualification word or the enable mask. The packed qualification word can be observed on a dedicated output, which always shows its unused upper half as zero. Halting the core, sequencing of triggers and the transport of debug commands belong to other blocks.

Top module: `pc_bkpt_qual`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, all hit outputs are 0 and the qualification word output reads 0x00000000, so every qualification code is zero.
- R2: A comparator reports a hit on `hit_o[n]` exactly one clock after a cycle in which `inst_valid_i` is 1 and `pc_i` equals its full 32-bit programmed address; with `inst_valid_i` at 0 no hit is reported.
- R3: A comparator whose bit in the enable mask is 0 never hits, whatever its address and qualification code.
- R4: The qualification word packs comparator n's 4-bit code into bits 4n+3..4n (comparator 0 in bits 3..0, comparator 3 in bits 15..12); bits 31..16 always read as 0 even when written with ones.
- R5: When bit 2 of a comparator's code is 1, a hit also needs `asid_i` to equal that comparator's programmed 8-bit identifier.
- R6: When bit 1 of a code is 1, a hit also needs the privilege mode to match bit 0 of the code: bit 0 = 0 requires `super_i` = 0 (user), bit 0 = 1 requires `super_i` = 1 (supervisor).
- R7: Bit 3 of a code never affects hits, and bit 0 has no effect while bit 1 is 0.
- R8: With bits 2 and 1 both set, a hit needs address, identifier and selected mode to match together.
- R9: `hit_any_o` is 1 in exactly the cycles where at least one bit of `hit_o` is 1.
- R10: A write with `wr_en_i` = 1 takes effect at the clock edge. `wr_sel_i` 0..3 loads the address of comparator 0..3 from `wr_data_i`. Selects 4..7 load the identifier of comparator 0..3 from `wr_data_i[7:0]`. Select 8 loads the qualification word, and select 9 loads the enable mask from `wr_data_i[3:0]`, with bit n enabling comparator n.
- R11: Comparators are evaluated independently: two comparators on the same address with different codes hit separately, according to their own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Write target select (see R10) |
| wr_data_i | input | 32 | Write data |
| inst_valid_i | input | 1 | Instruction address valid this cycle |
| pc_i | input | 32 | Executing instruction address |
| asid_i | input | 8 | Current address-space identifier |
| super_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| hit_o | output | 4 | Registered per-comparator hit |
| hit_any_o | output | 1 | Registered OR of all comparator hits |
| ctrl_o | output | 32 | Current packed qualification word |

## Verification
On every cycle, the assertions check the safety side of each hit. A reported hit must follow a valid instruction on an enabled comparator with an equal address. When its code asks for them, the identifier and mode must also agree. The combined hit must track the individual ones, and a write of the qualification word must land in the packed field positions. The bench scenarios are what show the other direction: expected hits actually occur for each code, bit 3 and a masked bit 0 are ignored, reserved bits read back as zero, and two comparators on one address separate by mode.

// File: rtl/pbq_pkg.sv
`timescale 1ns/1ps
package pbq_pkg;
  // Width of one packed qualification code
  localparam int CODE_W = 4;
  // Bit positions inside one code
  localparam int CB_ASID = 2;
  localparam int CB_MODE = 1;
  localparam int CB_SUP  = 0;

  typedef struct packed {
    logic asid_req;
    logic mode_req;
    logic want_sup;
  } qual_t;

  function automatic qual_t code_to_qual(input logic [CODE_W-1:0] code);
    qual_t q;
    q.asid_req = code[CB_ASID];
    q.mode_req = code[CB_MODE];
    q.want_sup = code[CB_SUP];
    return q;
  endfunction
endpackage

// File: rtl/pbq_rst_sync.sv
`timescale 1ns/1ps
module pbq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pbq_regs.sv
`timescale 1ns/1ps
module pbq_regs
  import pbq_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  localparam int USED_W = NUM_BP * CODE_W,
  localparam int SEL_W  = $clog2(2 * NUM_BP + 2)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_addr_o,
  output logic [NUM_BP-1:0][ASID_W-1:0]  bp_asid_o,
  output logic [USED_W-1:0]              codes_o,
  output logic [NUM_BP-1:0]              bp_en_o,
  output logic [DATA_W-1:0]              ctrl_o
);
  localparam int SEL_ASID0 = NUM_BP;
  localparam int SEL_CTRL  = 2 * NUM_BP;
  localparam int SEL_EN    = 2 * NUM_BP + 1;

  logic [NUM_BP-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [NUM_BP-1:0][ASID_W-1:0] asid_q, asid_d;
  logic [USED_W-1:0]             code_q, code_d;
  logic [NUM_BP-1:0]             en_q,   en_d;
  logic                          addr_ce, asid_ce, code_ce, en_ce;

  // Clock enables per register class
  always_comb begin
    addr_ce = wr_en_i && (int'(wr_sel_i) <  SEL_ASID0);
    asid_ce = wr_en_i && (int'(wr_sel_i) >= SEL_ASID0) && (int'(wr_sel_i) < SEL_CTRL);
    code_ce = wr_en_i && (int'(wr_sel_i) == SEL_CTRL);
    en_ce   = wr_en_i && (int'(wr_sel_i) == SEL_EN);
  end

  // Next-state values
  always_comb begin
    addr_d = addr_q;
    asid_d = asid_q;
    for (int n = 0; n < NUM_BP; n++) begin
      if (int'(wr_sel_i) == n)             addr_d[n] = wr_data_i[ADDR_W-1:0];
      if (int'(wr_sel_i) == SEL_ASID0 + n) asid_d[n] = wr_data_i[ASID_W-1:0];
    end
    code_d = wr_data_i[USED_W-1:0];
    en_d   = wr_data_i[NUM_BP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      asid_q <= '0;
      code_q <= '0;
      en_q   <= '0;
    end else begin
      if (addr_ce) addr_q <= addr_d;
      if (asid_ce) asid_q <= asid_d;
      if (code_ce) code_q <= code_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign bp_addr_o = addr_q;
  assign bp_asid_o = asid_q;
  assign codes_o   = code_q;
  assign bp_en_o   = en_q;
  assign ctrl_o    = {{(DATA_W-USED_W){1'b0}}, code_q};

  AST_CTRL_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(wr_sel_i) == SEL_CTRL) |=> (ctrl_o == {{(DATA_W-USED_W){1'b0}}, $past(wr_data_i[USED_W-1:0])})); // R4
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(wr_sel_i) == SEL_EN) |=> (bp_en_o == $past(wr_data_i[NUM_BP-1:0]))); // R10
endmodule

// File: rtl/pbq_cmp.sv
`timescale 1ns/1ps
module pbq_cmp
  import pbq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              super_i,
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic [ASID_W-1:0] bp_asid_i,
  input  qual_t             qual_i,
  input  logic              bp_en_i,
  output logic              match_o,
  output logic              hit_o
);
  logic addr_eq, asid_ok, mode_ok;
  logic hit_q, hit_d;

  always_comb begin
    addr_eq = (pc_i == bp_addr_i);
    asid_ok = !qual_i.asid_req || (asid_i == bp_asid_i);
    mode_ok = !qual_i.mode_req || (super_i == qual_i.want_sup);
    match_o = inst_valid_i && bp_en_i && addr_eq && asid_ok && mode_ok;
    hit_d   = match_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(inst_valid_i)); // R2
  AST_HIT_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ($past(pc_i) == $past(bp_addr_i))); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(bp_en_i)); // R3
  AST_ASID_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && $past(qual_i.asid_req)) |-> ($past(asid_i) == $past(bp_asid_i))); // R5
  AST_MODE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && $past(qual_i.mode_req)) |-> ($past(super_i) == $past(qual_i.want_sup))); // R6
endmodule

// File: rtl/pc_bkpt_qual.sv
`timescale 1ns/1ps
module pc_bkpt_qual
  import pbq_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(2 * NUM_BP + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inst_valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              super_i,
  output logic [NUM_BP-1:0] hit_o,
  output logic              hit_any_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int USED_W = NUM_BP * CODE_W;

  logic                          rst_sync_n;
  logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
  logic [NUM_BP-1:0][ASID_W-1:0] bp_asid;
  logic [USED_W-1:0]             codes;
  logic [NUM_BP-1:0]             bp_en;
  logic [NUM_BP-1:0]             match;
  logic                          any_q, any_d;

  pbq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbq_regs #(
    .NUM_BP (NUM_BP),
    .ADDR_W (ADDR_W),
    .ASID_W (ASID_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .bp_addr_o (bp_addr),
    .bp_asid_o (bp_asid),
    .codes_o   (codes),
    .bp_en_o   (bp_en),
    .ctrl_o    (ctrl_o)
  );

  for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
    qual_t qual_n;
    logic  unused_spare_bit;
    assign qual_n           = code_to_qual(codes[n*CODE_W +: CODE_W]);
    assign unused_spare_bit = codes[n*CODE_W + CODE_W - 1];

    pbq_cmp #(
      .ADDR_W (ADDR_W),
      .ASID_W (ASID_W)
    ) u_cmp (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .inst_valid_i (inst_valid_i),
      .pc_i         (pc_i),
      .asid_i       (asid_i),
      .super_i      (super_i),
      .bp_addr_i    (bp_addr[n]),
      .bp_asid_i    (bp_asid[n]),
      .qual_i       (qual_n),
      .bp_en_i      (bp_en[n]),
      .match_o      (match[n]),
      .hit_o        (hit_o[n])
    );
  end

  always_comb begin
    any_d = |match;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) any_q <= 1'b0;
    else             any_q <= any_d;
  end

  assign hit_any_o = any_q;

  AST_ANY_TRACKS_HITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_any_o == (|hit_o)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (hit_o == '0 && !hit_any_o)); // R1
endmodule

// File: tb/pc_bkpt_qual_bench.sv
`timescale 1ns/1ps
module pc_bkpt_qual_bench;
  localparam time TCLK = 20ns;
  localparam int  WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [31:0] wr_data;
  logic        inst_valid;
  logic [31:0] pc;
  logic [7:0]  asid;
  logic        sup;
  logic [3:0]  hit;
  logic        hit_any;
  logic [31:0] ctrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench shadow of programmed state
  logic [31:0] sh_addr [4];
  logic [7:0]  sh_asid [4];
  logic [15:0] sh_code;
  logic [3:0]  sh_en;

  localparam logic [31:0] A0 = 32'h0000_1000;
  localparam logic [31:0] A1 = 32'h0000_2004;
  localparam logic [31:0] A2 = 32'h8000_0000;
  localparam logic [31:0] A3 = 32'hFFFF_FFFC;

  always #(TCLK/2) clk = ~clk;

  pc_bkpt_qual u_pc_bkpt_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .inst_valid_i (inst_valid),
    .pc_i         (pc),
    .asid_i       (asid),
    .super_i      (sup),
    .hit_o        (hit),
    .hit_any_o    (hit_any),
    .ctrl_o       (ctrl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Model built from R2, R3, R5, R6, R7, R8
  function automatic logic [3:0] model(input logic v, input logic [31:0] p,
                                       input logic [7:0] a, input logic s);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      logic [3:0] c;
      c = sh_code[4*n +: 4];
      r[n] = v && sh_en[n] && (p == sh_addr[n]) &&
             (!c[2] || a == sh_asid[n]) && (!c[1] || s == c[0]);
    end
    return r;
  endfunction

  task automatic wr(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 4)       sh_addr[sel]   = data;
    else if (sel < 8)  sh_asid[sel-4] = data[7:0];
    else if (sel == 8) sh_code        = data[15:0];
    else if (sel == 9) sh_en          = data[3:0];
  endtask

  // Present one instruction, compare the registered result one clock later
  task automatic issue(input logic v, input logic [31:0] p, input logic [7:0] a,
                       input logic s, input logic [3:0] exp_explicit, input string req);
    logic [3:0] exp;
    exp = model(v, p, a, s);
    @(negedge clk);
    inst_valid = v; pc = p; asid = a; sup = s;
    @(negedge clk);
    inst_valid = 1'b0;
    check(exp == exp_explicit, req, "bench model vs scenario", {28'd0, exp}, {28'd0, exp_explicit});
    check(hit == exp, req, "hit_o", {28'd0, hit}, {28'd0, exp});
    check(hit_any == (|exp), "R9", "hit_any_o", {31'd0, hit_any}, {31'd0, |exp});
  endtask

  task automatic t_reset;
    check(hit == 4'h0, "R1", "hit_o after reset", {28'd0, hit}, 32'd0);
    check(hit_any == 1'b0, "R1", "hit_any_o after reset", {31'd0, hit_any}, 32'd0);
    check(ctrl == 32'h0, "R1", "ctrl_o after reset", ctrl, 32'h0);
    issue(1'b1, 32'h0, 8'h00, 1'b0, 4'b0000, "R3"); // all disabled at reset
  endtask

  task automatic t_addr;
    wr(4'd0, A0); wr(4'd1, A1); wr(4'd2, A2); wr(4'd3, A3);
    wr(4'd9, 32'h0000_000F);
    issue(1'b1, A0, 8'h00, 1'b0, 4'b0001, "R2");
    issue(1'b1, A1, 8'h00, 1'b1, 4'b0010, "R2");
    issue(1'b1, A2, 8'h77, 1'b0, 4'b0100, "R10");
    issue(1'b1, A3, 8'h00, 1'b1, 4'b1000, "R10");
    issue(1'b0, A0, 8'h00, 1'b0, 4'b0000, "R2"); // no valid strobe
    issue(1'b1, A0 + 32'd4, 8'h00, 1'b0, 4'b0000, "R2"); // near miss
    issue(1'b1, A0 ^ 32'h8000_0000, 8'h00, 1'b0, 4'b0000, "R2"); // top bit differs
  endtask

  task automatic t_enable;
    wr(4'd9, 32'hFFFF_FFF5); // bits 0 and 2 only
    issue(1'b1, A1, 8'h00, 1'b0, 4'b0000, "R3");
    issue(1'b1, A2, 8'h00, 1'b0, 4'b0100, "R3");
    wr(4'd9, 32'h0000_000F);
  endtask

  task automatic t_pack;
    wr(4'd8, 32'hFFFF_F00F);
    check(ctrl == 32'h0000_F00F, "R4", "ctrl_o reserved bits", ctrl, 32'h0000_F00F);
    wr(4'd5, 32'h0000_005A);
    wr(4'd8, 32'h0000_0040); // comparator 1 asks for identifier
    check(ctrl == 32'h0000_0040, "R4", "ctrl_o readback", ctrl, 32'h0000_0040);
    issue(1'b1, A1, 8'h00, 1'b0, 4'b0000, "R4");
    issue(1'b1, A0, 8'h00, 1'b0, 4'b0001, "R4");
    issue(1'b1, A1, 8'h5A, 1'b0, 4'b0010, "R4");
  endtask

  task automatic t_asid;
    wr(4'd4, 32'h11); wr(4'd5, 32'h22); wr(4'd6, 32'h33); wr(4'd7, 32'h44);
    wr(4'd8, 32'h0000_4444);
    issue(1'b1, A2, 8'h33, 1'b0, 4'b0100, "R5");
    issue(1'b1, A2, 8'h34, 1'b0, 4'b0000, "R5");
    issue(1'b1, A0, 8'h11, 1'b1, 4'b0001, "R5");
  endtask

  task automatic t_mode;
    wr(4'd8, 32'h0000_0032); // cmp0 user only, cmp1 supervisor only
    issue(1'b1, A0, 8'h00, 1'b0, 4'b0001, "R6");
    issue(1'b1, A0, 8'h00, 1'b1, 4'b0000, "R6");
    issue(1'b1, A1, 8'h00, 1'b1, 4'b0010, "R6");
    issue(1'b1, A1, 8'h00, 1'b0, 4'b0000, "R6");
  endtask

  task automatic t_ignore;
    wr(4'd8, 32'h0000_0981); // cmp0 bit0 only, cmp1 bit3 only, cmp2 bits 3 and 0
    issue(1'b1, A0, 8'h99, 1'b1, 4'b0001, "R7");
    issue(1'b1, A1, 8'h99, 1'b0, 4'b0010, "R7");
    issue(1'b1, A2, 8'h99, 1'b0, 4'b0100, "R7");
  endtask

  task automatic t_both;
    wr(4'd8, 32'h0000_7000);
    issue(1'b1, A3, 8'h44, 1'b1, 4'b1000, "R8");
    issue(1'b1, A3, 8'h44, 1'b0, 4'b0000, "R8");
    issue(1'b1, A3, 8'h45, 1'b1, 4'b0000, "R8");
    wr(4'd8, 32'h0000_6000); // user variant
    issue(1'b1, A3, 8'h44, 1'b0, 4'b1000, "R8");
  endtask

  task automatic t_indep;
    wr(4'd1, A0);
    wr(4'd8, 32'h0000_0032);
    issue(1'b1, A0, 8'h00, 1'b0, 4'b0001, "R11");
    issue(1'b1, A0, 8'h00, 1'b1, 4'b0010, "R11");
    wr(4'd8, 32'h0000_0000);
    issue(1'b1, A0, 8'h00, 1'b1, 4'b0011, "R11");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    inst_valid = 1'b0; pc = '0; asid = '0; sup = 1'b0;
    for (int n = 0; n < 4; n++) begin sh_addr[n] = '0; sh_asid[n] = '0; end
    sh_code = '0; sh_en = '0;
    repeat (3) @(negedge clk);
    check(hit == 4'h0 && ctrl == 32'h0, "R1", "outputs in reset", {28'd0, hit}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_enable();
    t_pack();
    t_asid();
    t_mode();
    t_ignore();
    t_both();
    t_indep();
    summary();
  end
endmodule